// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a serial-bus slave engine of a byte-addressable non-volatile memory and handles the write side of it. The engine signals the start of a write transaction, hands over the target address once it has been received, and then streams the data bytes over a valid/ready channel. Each accepted byte is answered one cycle later with an acknowledge or refuse decision. Accepted bytes are latched into a one-page buffer at an offset that advances and wraps within the page, and a per-offset mask records which offsets were received.

On the stop strobe, if at least one byte was stored, the block runs one timed write cycle. It stays busy for a fixed, parameterized number of clocks, and in the first page-length cycles of that window it issues one memory write for each stored offset, in ascending offset order. A separate identification page uses the same path and can be locked against writing; a short ID write made of one data byte and ended by a new start reports the lock state through the acknowledge and commits nothing.

Back-pressure rules on the data stream: `wr_ready` is high only in the data phase of a transaction and only while the block is idle. The engine holds `wr_valid` and `wr_data` until a cycle in which both are high. A byte counts as transferred only in that cycle, and a transfer always produces exactly one response.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset `busy`, `wr_ready`, `resp_valid` and `mem_we` are all low, and the ID page is unlocked.
- R2: `wr_ready` is high exactly when the block is not busy and a transaction has received its address and not yet ended.
- R3: A byte transferred in cycle N gives `resp_valid`=1 in cycle N+1, with `resp_ack`=1 when the byte was stored; `resp_valid` is low otherwise.
- R4: A byte transferred while `wc` is high is answered with `resp_ack`=0 and is neither stored nor later written to memory.
- R5: The first byte goes to the offset given by the low 8 address bits; each further transferred byte (stored or refused) advances the offset by one modulo 256 while the upper address bits stay fixed, so a byte past offset 255 lands on offset 0 and a later byte at an offset replaces the earlier one.
- R6: A stop in a transaction that holds at least one stored byte raises `busy` in the next cycle for exactly `WR_CYCLES` consecutive cycles.
- R7: During that busy window the block asserts `mem_we` once for each stored offset, in ascending offset order, with `mem_addr` = {upper page bits, offset}, the last data stored there on `mem_wdata`, and `mem_id_page` equal to the transaction's ID-page select. Nothing else is written to memory.
- R8: A transaction that ends with no stored byte, or is cut short by a new start, writes nothing and leaves `busy` low; its stored bytes are discarded.
- R9: A pulse on `id_lock_req` while idle locks the ID page until reset. Bytes sent to the ID page while it is locked get `resp_ack`=0 and are never written. A single-byte ID write ended by a new start therefore answers ack when the page is unlocked and refuse when it is locked.
- R10: While `busy` is high, `txn_start`, `addr_valid`, `txn_stop` and `id_lock_req` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wc | input | 1 | Write protect: high refuses main-array and ID-page data bytes |
| id_lock_req | input | 1 | Pulse that locks the ID page |
| txn_start | input | 1 | Pulse: a write transaction begins (also aborts one in progress) |
| txn_id_page | input | 1 | With `txn_start`: 1 selects the ID page, 0 the main array |
| addr_valid | input | 1 | Pulse: `addr` carries the transaction's start address |
| addr | input | ADDR_W | Byte address; upper bits select the page, low 8 bits the offset |
| wr_valid | input | 1 | Data byte offered |
| wr_ready | output | 1 | Data byte can be taken this cycle |
| wr_data | input | 8 | Data byte |
| txn_stop | input | 1 | Pulse: the transaction ends |
| resp_valid | output | 1 | Response for the byte transferred in the previous cycle |
| resp_ack | output | 1 | 1 = acknowledge, 0 = refuse |
| mem_we | output | 1 | Memory write strobe |
| mem_id_page | output | 1 | Write targets the ID page |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Write cycle in progress |

## Verification
The properties take for granted that the engine never pulses `txn_start` and `txn_stop` in the same cycle and never raises a strobe together with a data transfer. They also assume that `addr_valid` comes only between a start and the first data byte. The stimulus drives every strobe as a single-cycle pulse from its own task and sends data only after the address, so these orderings hold throughout. The one exception is the deliberate start or stop pulses during a busy window, which exercise the ignore rule.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;
endpackage

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
  parameter int PAGE_BITS = 8,
  parameter int DATA_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [PAGE_BITS-1:0]       wr_off,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       clr,
  input  logic [PAGE_BITS-1:0]       rd_off,
  output logic [DATA_W-1:0]          rd_data,
  output logic [(1<<PAGE_BITS)-1:0]  mask
);
  localparam int DEPTH = 1 << PAGE_BITS;

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[wr_off] <= wr_data;
  end

  assign rd_data = store_q[rd_off];

  // one received-flag per offset
  for (genvar g = 0; g < DEPTH; g++) begin : g_mask
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 seen_q <= 1'b0;
      else if (clr)                               seen_q <= 1'b0;
      else if (we && wr_off == PAGE_BITS'(g))     seen_q <= 1'b1;
    end
    assign mask[g] = seen_q;
  end
endmodule

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int PAGE_BITS = 8,
  parameter int DATA_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        busy,
  input  logic                        any_stored,
  input  logic                        wc,
  input  logic                        id_lock_req,
  input  logic                        txn_start,
  input  logic                        txn_id_page,
  input  logic                        addr_valid,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr_valid,
  output logic                        wr_ready,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        txn_stop,
  output logic                        resp_valid,
  output logic                        resp_ack,
  output logic                        buf_we,
  output logic [PAGE_BITS-1:0]        buf_off,
  output logic [DATA_W-1:0]           buf_data,
  output logic                        buf_clr,
  output logic                        commit_go,
  output logic [ADDR_W-PAGE_BITS-1:0] page_sel,
  output logic                        id_sel,
  output logic                        id_locked
);
  phase_t                        phase_q;
  logic [PAGE_BITS-1:0]          ptr_q;
  logic [ADDR_W-PAGE_BITS-1:0]   page_q;
  logic                          id_q;
  logic                          locked_q;
  logic                          rv_q, ra_q;
  logic                          accept, allowed;

  assign wr_ready  = (phase_q == PH_DATA) && !busy;
  assign accept    = wr_valid && wr_ready;
  assign allowed   = !wc && !(id_q && locked_q);
  assign buf_we    = accept && allowed;
  assign buf_off   = ptr_q;
  assign buf_data  = wr_data;
  assign commit_go = !busy && txn_stop && (phase_q == PH_DATA) && any_stored;
  assign buf_clr   = !busy && (txn_start || (txn_stop && !commit_go));

  assign page_sel   = page_q;
  assign id_sel     = id_q;
  assign id_locked  = locked_q;
  assign resp_valid = rv_q;
  assign resp_ack   = ra_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ptr_q   <= '0;
      page_q  <= '0;
      id_q    <= 1'b0;
    end else if (!busy) begin
      if (txn_start) begin
        phase_q <= PH_ADDR;
        id_q    <= txn_id_page;
      end else if (txn_stop) begin
        phase_q <= PH_IDLE;
      end else if (addr_valid && phase_q == PH_ADDR) begin
        phase_q <= PH_DATA;
        ptr_q   <= addr[PAGE_BITS-1:0];
        page_q  <= id_q ? '0 : addr[ADDR_W-1:PAGE_BITS];
      end else if (accept) begin
        ptr_q   <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      ra_q <= 1'b0;
    end else begin
      rv_q <= accept;
      ra_q <= accept && allowed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     locked_q <= 1'b0;
    else if (id_lock_req && !busy)  locked_q <= 1'b1;
  end
endmodule

// File: rtl/pwc_commit.sv
module pwc_commit #(
  parameter int ADDR_W    = 17,
  parameter int PAGE_BITS = 8,
  parameter int WR_CYCLES = 300
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  input  logic [ADDR_W-PAGE_BITS-1:0] page_in,
  input  logic                        id_in,
  input  logic [(1<<PAGE_BITS)-1:0]   mask,
  output logic [PAGE_BITS-1:0]        rd_off,
  output logic                        busy,
  output logic                        done,
  output logic                        mem_we,
  output logic                        mem_id_page,
  output logic [ADDR_W-1:0]           mem_addr
);
  localparam int DEPTH = 1 << PAGE_BITS;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic                        active_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [ADDR_W-PAGE_BITS-1:0] page_q;
  logic                        id_q;
  logic                        in_scan;

  assign rd_off      = cnt_q[PAGE_BITS-1:0];
  assign in_scan     = cnt_q < CNT_W'(DEPTH);
  assign busy        = active_q;
  assign done        = active_q && (cnt_q == CNT_W'(WR_CYCLES - 1));
  assign mem_we      = active_q && in_scan && mask[rd_off];
  assign mem_id_page = id_q;
  assign mem_addr    = {page_q, rd_off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      page_q   <= '0;
      id_q     <= 1'b0;
    end else if (!active_q) begin
      if (go) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        page_q   <= page_in;
        id_q     <= id_in;
      end
    end else if (done) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
  parameter int ADDR_W    = 17,
  parameter int PAGE_BITS = 8,
  parameter int WR_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wc,
  input  logic              id_lock_req,
  input  logic              txn_start,
  input  logic              txn_id_page,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic              txn_stop,
  output logic              resp_valid,
  output logic              resp_ack,
  output logic              mem_we,
  output logic              mem_id_page,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy
);
  localparam int DEPTH = 1 << PAGE_BITS;

  logic                        buf_we, ctl_clr, commit_go, done, any_stored;
  logic [PAGE_BITS-1:0]        buf_off, rd_off;
  logic [7:0]                  buf_data;
  logic [DEPTH-1:0]            mask;
  logic [ADDR_W-PAGE_BITS-1:0] page_sel;
  logic                        ctl_id_sel, ctl_locked;

  assign any_stored = |mask;

  pwc_ctrl #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(8)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busy(busy), .any_stored(any_stored),
    .wc(wc), .id_lock_req(id_lock_req), .txn_start(txn_start),
    .txn_id_page(txn_id_page), .addr_valid(addr_valid), .addr(addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .txn_stop(txn_stop), .resp_valid(resp_valid), .resp_ack(resp_ack),
    .buf_we(buf_we), .buf_off(buf_off), .buf_data(buf_data),
    .buf_clr(ctl_clr), .commit_go(commit_go), .page_sel(page_sel),
    .id_sel(ctl_id_sel), .id_locked(ctl_locked)
  );

  pwc_page_buf #(.PAGE_BITS(PAGE_BITS), .DATA_W(8)) u_buf (
    .clk(clk), .rst_n(rst_n), .we(buf_we), .wr_off(buf_off),
    .wr_data(buf_data), .clr(ctl_clr || done), .rd_off(rd_off),
    .rd_data(mem_wdata), .mask(mask)
  );

  pwc_commit #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WR_CYCLES(WR_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n), .go(commit_go), .page_in(page_sel),
    .id_in(ctl_id_sel), .mask(mask), .rd_off(rd_off), .busy(busy),
    .done(done), .mem_we(mem_we), .mem_id_page(mem_id_page),
    .mem_addr(mem_addr)
  );
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int WR_CYCLES = 300
) (
  input logic clk,
  input logic rst_n,
  input logic wc,
  input logic wr_valid,
  input logic wr_ready,
  input logic resp_valid,
  input logic resp_ack,
  input logic mem_we,
  input logic busy,
  input logic id_sel,
  input logic id_locked
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  a_r2_ready_low_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  a_r3_resp_follows_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> resp_valid);

  a_r3_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> !resp_valid);

  a_r4_wc_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wc) |=> (resp_valid && !resp_ack));

  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && busy_run != 0) |-> (busy_run == WR_CYCLES));

  a_r7_write_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r9_lock_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    id_locked |=> id_locked);

  a_r9_locked_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && id_sel && id_locked) |=> !resp_ack);
endmodule

bind page_write_ctrl pwc_checker #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wc(wc), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .resp_valid(resp_valid), .resp_ack(resp_ack),
  .mem_we(mem_we), .busy(busy), .id_sel(ctl_id_sel), .id_locked(ctl_locked)
);

// File: tb/page_write_ctrl_tb.sv
`timescale 1ns/1ps
module page_write_ctrl_tb;
  localparam int ADDR_W = 17;
  localparam int WRC    = 300;

  logic clk = 0, rst_n = 0;
  logic wc = 0, id_lock_req = 0, txn_start = 0, txn_id_page = 0;
  logic addr_valid = 0, wr_valid = 0, txn_stop = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic wr_ready, resp_valid, resp_ack, mem_we, mem_id_page, busy;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;

  always #10 clk = ~clk;

  page_write_ctrl #(.ADDR_W(ADDR_W), .PAGE_BITS(8), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wc(wc), .id_lock_req(id_lock_req),
    .txn_start(txn_start), .txn_id_page(txn_id_page), .addr_valid(addr_valid),
    .addr(addr), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .txn_stop(txn_stop), .resp_valid(resp_valid), .resp_ack(resp_ack),
    .mem_we(mem_we), .mem_id_page(mem_id_page), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy)
  );

  int checks = 0, errors = 0, cycles = 0, writes_seen = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_phase = 0;           // 0 idle, 1 wait address, 2 data
  bit m_busy = 0, m_id = 0, m_locked = 0, m_rv = 0, m_ra = 0;
  int m_cnt = 0, m_ptr = 0, m_page = 0;
  bit m_mask [256];
  int m_buf  [256];
  int exp_q [$];             // {id, addr, data}

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_busy = 0; m_id = 0; m_locked = 0; m_rv = 0; m_ra = 0;
      m_cnt = 0; m_ptr = 0; m_page = 0;
      foreach (m_mask[i]) m_mask[i] = 0;
    end else begin
      bit rv_n, ra_n, any;
      rv_n = 0; ra_n = 0;
      if (m_busy) begin
        if (m_cnt == WRC - 1) m_busy = 0;
        else m_cnt++;
      end else begin
        if (txn_start) begin
          m_phase = 1; m_id = txn_id_page;
          foreach (m_mask[i]) m_mask[i] = 0;
        end else if (txn_stop) begin
          any = 0;
          foreach (m_mask[i]) any |= m_mask[i];
          if (m_phase == 2 && any) begin
            for (int o = 0; o < 256; o++)
              if (m_mask[o]) exp_q.push_back({m_id, 17'(m_page * 256 + o), 8'(m_buf[o])});
            m_busy = 1; m_cnt = 0;
          end
          foreach (m_mask[i]) m_mask[i] = 0;
          m_phase = 0;
        end else if (addr_valid && m_phase == 1) begin
          m_page = m_id ? 0 : int'(addr) / 256;
          m_ptr = int'(addr) % 256;
          m_phase = 2;
        end else if (wr_valid && m_phase == 2) begin
          bit ok;
          ok = !wc && !(m_id && m_locked);
          if (ok) begin m_buf[m_ptr] = wr_data; m_mask[m_ptr] = 1; end
          m_ptr = (m_ptr + 1) % 256;
          rv_n = 1; ra_n = ok;
        end
        if (id_lock_req) m_locked = 1;
      end
      m_rv = rv_n; m_ra = ra_n;
    end
  end

  bit prev_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R6 busy", busy, m_busy);
      chk(wr_ready == (m_phase == 2 && !m_busy), "R2 ready", wr_ready, (m_phase == 2 && !m_busy));
      chk(resp_valid == m_rv, {cur_req, " resp_valid"}, resp_valid, m_rv);
      if (m_rv) chk(resp_ack == m_ra, {cur_req, " resp_ack"}, resp_ack, m_ra);
      if (mem_we) begin
        writes_seen++;
        if (exp_q.size() == 0) chk(0, {cur_req, " R7 unexpected write"}, mem_addr, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk({mem_id_page, mem_addr, mem_wdata} == 26'(e), {cur_req, " R7 write"},
              {mem_id_page, mem_addr, mem_wdata}, e);
        end
      end
      if (prev_busy && !m_busy) chk(exp_q.size() == 0, {cur_req, " R7 missing writes"}, exp_q.size(), 0);
      prev_busy = m_busy;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(); @(posedge clk); #1; endtask
  task automatic p_start(input bit id);
    txn_start = 1; txn_id_page = id; step(); txn_start = 0; txn_id_page = 0;
  endtask
  task automatic p_addr(input int a);
    addr_valid = 1; addr = ADDR_W'(a); step(); addr_valid = 0;
  endtask
  task automatic p_data(input int d);
    wr_valid = 1; wr_data = 8'(d); step(); wr_valid = 0;
  endtask
  task automatic p_stop(); txn_stop = 1; step(); txn_stop = 0; endtask
  task automatic p_lock(); id_lock_req = 1; step(); id_lock_req = 0; endtask
  task automatic wait_idle(); step(); while (busy) step(); step(); endtask

  initial begin
    int w0;
    repeat (3) step();
    // R1 reset state, observed while reset is held
    chk(!busy && !wr_ready && !resp_valid && !mem_we, "R1 reset outputs",
        {busy, wr_ready, resp_valid, mem_we}, 0);
    rst_n = 1; step();

    cur_req = "R6 byte write";
    w0 = writes_seen;
    p_start(0); p_addr('h12345); p_data('hA5); p_stop();
    chk(busy == 1, "R6 busy after stop", busy, 1);
    wait_idle();
    chk(writes_seen - w0 == 1, "R7 single write count", writes_seen - w0, 1);

    cur_req = "R5 rollover";
    w0 = writes_seen;
    p_start(0); p_addr('h1FE);
    for (int k = 0; k < 4; k++) p_data('h10 + k);
    p_stop(); wait_idle();
    chk(writes_seen - w0 == 4, "R5 rollover write count", writes_seen - w0, 4);

    cur_req = "R5 overwrite";
    w0 = writes_seen;
    p_start(0); p_addr('h0A00);
    for (int k = 0; k < 258; k++) p_data((k & 255) ^ 'h5A ^ (k >> 8));
    p_stop(); wait_idle();
    chk(writes_seen - w0 == 256, "R5 full page write count", writes_seen - w0, 256);

    cur_req = "R4 write protect";
    w0 = writes_seen;
    wc = 1;
    p_start(0); p_addr('h300); p_data('h11);
    chk(resp_valid && !resp_ack, "R4 nack under wc", {resp_valid, resp_ack}, 2);
    p_data('h22); p_stop(); step();
    chk(busy == 0, "R4 no commit under wc", busy, 0);
    wc = 0;
    chk(writes_seen - w0 == 0, "R4 no write under wc", writes_seen - w0, 0);

    cur_req = "R4 mixed";
    w0 = writes_seen;
    p_start(0); p_addr('h4F0); p_data('h01); wc = 1; p_data('h02); wc = 0; p_data('h03);
    p_stop(); wait_idle();
    chk(writes_seen - w0 == 2, "R4 only unprotected bytes written", writes_seen - w0, 2);

    cur_req = "R8 empty";
    p_start(0); p_addr('h500); p_stop(); step();
    chk(busy == 0, "R8 no data no commit", busy, 0);
    w0 = writes_seen;
    p_start(0); p_addr('h600); p_data('h77); p_start(0); p_stop(); step();
    chk(busy == 0, "R8 aborted by start", busy, 0);
    chk(writes_seen - w0 == 0, "R8 aborted writes", writes_seen - w0, 0);

    cur_req = "R10 busy";
    p_start(0); p_addr('h700); p_data('h99); p_stop();
    p_start(1); p_addr('h10); p_lock(); p_stop();
    chk(wr_ready == 0, "R10 ready stays low while busy", wr_ready, 0);
    wait_idle();
    w0 = writes_seen;
    p_stop(); step();
    chk(busy == 0, "R10 ignored start left nothing open", busy, 0);

    cur_req = "R9 id unlocked";
    p_start(1); p_addr('h20); p_data('h3C);
    chk(resp_ack == 1, "R9 unlocked status ack", resp_ack, 1);
    p_start(0); step(); p_stop();
    p_start(1); p_addr('h20); p_data('h3C); p_data('h3D); p_stop(); wait_idle();
    chk(writes_seen - w0 == 2, "R9 id page written", writes_seen - w0, 2);

    cur_req = "R9 id locked";
    p_lock();
    w0 = writes_seen;
    p_start(1); p_addr('h00); p_data('hEE);
    chk(resp_ack == 0, "R9 locked status nack", resp_ack, 0);
    p_data('hEF); p_stop(); step();
    chk(busy == 0, "R9 locked write no commit", busy, 0);
    cur_req = "R9 main after lock";
    p_start(0); p_addr('h800); p_data('h42); p_stop(); wait_idle();
    chk(writes_seen - w0 == 1, "R9 main array still writable", writes_seen - w0, 1);

    repeat (3) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule